// File: doc/BRIEF.md
# Queued-Duty Pulse Width Modulator

This block generates a pulse-width modulated output whose high time is supplied one period at a time from a small queue of 16-bit duty samples. A host pushes samples and programs the period through a single-cycle register port. A period counter runs from zero to the programmed terminal value. At every period boundary the generator takes the next queued sample, or keeps the previous duty value when the queue is empty.

Pushing into a full queue drops the sample and latches a sticky error. While that error is set the generator is held stopped and consumes nothing. Each completed period with a nonzero duty latches a rollover flag, which can drive an interrupt. A soft-reset command empties the queue, clears the flags and the active duty, and disables the generator.

Top module: `pwm_fifo_gen`

## Requirements
- R1: The sample queue holds 4 entries of 16 bits. Status register bits [3:0] give the entry count and bit 4 is set when the queue is empty. After reset, status reads 0x0010.
- R2: With period value P, each period lasts P+1 clock cycles. The output is high for the first D cycles of a period whose active duty is D, and a duty of 0 keeps it low all period. The first period begins two clock edges after the enabling write.
- R3: Writing a sample while 4 entries are queued sets status bit 5 (write error). The error stays set until it is cleared, and the written sample is discarded.
- R4: While the write error is set, the output stays low and no queued sample is consumed, even with enable set. Clearing the error lets the generator start.
- R5: Status bit 6 (rollover) is set when a period with nonzero duty completes. No rollover is raised for a period whose duty is 0.
- R6: While enable is 0, no queue entry is consumed and the output is low.
- R7: Writing the control register with bit 2 set empties the queue, clears the error and rollover flags, clears the active duty and both control bits, and leaves the period register unchanged.
- R8: At each period boundary, the next queued sample becomes the active duty. When the queue is empty, the last active duty is repeated.
- R9: Writing 1 to status bit 5 or bit 6 clears that flag. Writing 0 leaves it unchanged.
- R10: irq_o is high exactly while the rollover flag is set and control bit 1 (interrupt enable) is 1.
- R11: Register map by address: 0 is control (bit 0 enable, bit 1 interrupt enable, bit 2 soft reset, which reads back 0). 1 pushes a sample on write and reads the active duty. 2 is the period. 3 is status. Reads return data combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| pwm_o | output | 1 | Modulated output |
| irq_o | output | 1 | Rollover interrupt |

## Verification
The assertions assume that every write lasts exactly one cycle, with a stable address, and that the period register is not rewritten while the generator runs. The stimulus follows both rules. It writes the period and queues samples only while the generator is disabled or the queue is empty, and it holds wr_i for a single clock edge. The counter-based duty checks also rely on every duty value staying at or below the period. All samples the bench uses meet this.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_SAMPLE = 2'd1,
    REG_PERIOD = 2'd2,
    REG_STATUS = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_IRQEN = 1;
  localparam int CTRL_SRST  = 2;

  localparam int ST_CNT_W = 4;
  localparam int ST_EMPTY = 4;
  localparam int ST_ERR   = 5;
  localparam int ST_ROLL  = 6;
endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (push_i && !flush_i && wr_ptr_q == AW'(i)) mem_q[i] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          run_i,
  input  logic [DW-1:0] period_i,
  input  logic [DW-1:0] head_i,
  input  logic          empty_i,
  output logic          pop_o,
  output logic          roll_o,
  output logic          pwm_o,
  output logic [DW-1:0] duty_o
);
  logic [DW-1:0] cnt_q, duty_q;
  logic          started_q;
  logic          at_end, boundary;

  assign at_end   = (cnt_q >= period_i);
  // first cycle of a run is treated as a boundary so a sample is loaded
  assign boundary = run_i && (!started_q || at_end);
  assign pop_o    = boundary && !empty_i;
  assign roll_o   = run_i && started_q && at_end && (duty_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      duty_q    <= '0;
      started_q <= 1'b0;
    end else if (flush_i) begin
      cnt_q     <= '0;
      duty_q    <= '0;
      started_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else if (boundary) begin
      cnt_q     <= '0;
      started_q <= 1'b1;
      if (!empty_i) duty_q <= head_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pwm_o  = run_i && started_q && (cnt_q < duty_q);
  assign duty_o = duty_q;
endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
  import pwm_fifo_pkg::*;
#(
  parameter int DW         = 16,
  parameter int DEPTH      = 4,
  parameter int PERIOD_RST = 16'hFFFF,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          pwm_o,
  output logic          irq_o
);
  logic          en_q, irqen_q, err_q, roll_q;
  logic [DW-1:0] period_q;
  logic          wr_ctrl, wr_sample, wr_period, wr_status, sreset;
  logic          fifo_push, fifo_pop, fifo_full, fifo_empty, err_set, roll_evt, run;
  logic [DW-1:0] fifo_head, duty_act;
  logic [CW-1:0] fifo_cnt;

  assign wr_ctrl   = wr_i && (addr_i == REG_CTRL);
  assign wr_sample = wr_i && (addr_i == REG_SAMPLE);
  assign wr_period = wr_i && (addr_i == REG_PERIOD);
  assign wr_status = wr_i && (addr_i == REG_STATUS);
  assign sreset    = wr_ctrl && wdata_i[CTRL_SRST];

  assign fifo_push = wr_sample && !fifo_full;
  assign err_set   = wr_sample && fifo_full;
  assign run       = en_q && !err_q;

  pwm_sample_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (sreset),
    .push_i  (fifo_push),
    .data_i  (wdata_i),
    .pop_i   (fifo_pop),
    .head_o  (fifo_head),
    .count_o (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  pwm_period_ctr #(.DW(DW)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (sreset),
    .run_i    (run),
    .period_i (period_q),
    .head_i   (fifo_head),
    .empty_i  (fifo_empty),
    .pop_o    (fifo_pop),
    .roll_o   (roll_evt),
    .pwm_o    (pwm_o),
    .duty_o   (duty_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      irqen_q  <= 1'b0;
      period_q <= DW'(PERIOD_RST);
    end else begin
      if (sreset) begin
        en_q    <= 1'b0;
        irqen_q <= 1'b0;
      end else if (wr_ctrl) begin
        en_q    <= wdata_i[CTRL_EN];
        irqen_q <= wdata_i[CTRL_IRQEN];
      end
      if (wr_period) period_q <= wdata_i;
    end
  end

  // set events win over a same-cycle write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      roll_q <= 1'b0;
    end else if (sreset) begin
      err_q  <= 1'b0;
      roll_q <= 1'b0;
    end else begin
      err_q  <= err_set  || (err_q  && !(wr_status && wdata_i[ST_ERR]));
      roll_q <= roll_evt || (roll_q && !(wr_status && wdata_i[ST_ROLL]));
    end
  end

  assign irq_o = roll_q && irqen_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: begin
        rdata_o[CTRL_EN]    = en_q;
        rdata_o[CTRL_IRQEN] = irqen_q;
      end
      REG_SAMPLE: rdata_o = duty_act;
      REG_PERIOD: rdata_o = period_q;
      default: begin
        rdata_o[ST_CNT_W-1:0] = ST_CNT_W'(fifo_cnt);
        rdata_o[ST_EMPTY]     = fifo_empty;
        rdata_o[ST_ERR]       = err_q;
        rdata_o[ST_ROLL]      = roll_q;
      end
    endcase
  end
endmodule

// File: rtl/pwm_fifo_chk.sv
module pwm_fifo_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic [1:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [CW-1:0] fifo_cnt_i,
  input logic          err_i,
  input logic          roll_i,
  input logic [DW-1:0] duty_i,
  input logic          run_i,
  input logic          pwm_i
);
  logic sreset_w;
  assign sreset_w = wr_i && (addr_i == 2'd0) && wdata_i[2];

  assert_count_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= CW'(DEPTH));

  assert_err_on_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd1 && fifo_cnt_i == CW'(DEPTH)) |=> err_i);

  assert_no_output_on_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !pwm_i);

  assert_no_zero_duty_roll_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(roll_i) |-> ($past(duty_i) != '0));

  assert_no_pop_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !sreset_w) |=> (fifo_cnt_i >= $past(fifo_cnt_i)));

  assert_soft_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreset_w |=> (fifo_cnt_i == '0 && !err_i && !roll_i && duty_i == '0));
endmodule

bind pwm_fifo_gen pwm_fifo_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .fifo_cnt_i (fifo_cnt),
  .err_i      (err_q),
  .roll_i     (roll_q),
  .duty_i     (duty_act),
  .run_i      (run),
  .pwm_i      (pwm_o)
);

// File: tb/sim_pwm_fifo_gen.sv
module sim_pwm_fifo_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        pwm_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pwm_fifo_gen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic idle_cycles(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      highs += int'(pwm_o);
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset;
    logic [15:0] d;
    reg_rd(2'd3, d); check("R1 reset status", d, 16'h0010);
    reg_rd(2'd0, d); check("R11 reset ctrl", d, 0);
    check("R6 reset pwm", pwm_o, 0);
    check("R10 reset irq", irq_o, 0);
  endtask

  task automatic t_sequence;
    logic [15:0] d;
    int h;
    reg_wr(2'd2, 16'd9);
    reg_rd(2'd2, d); check("R11 period readback", d, 9);
    reg_wr(2'd1, 16'd3);
    reg_wr(2'd1, 16'd0);
    reg_wr(2'd1, 16'd5);
    reg_rd(2'd3, d); check("R1 count after three pushes", d, 16'h0003);
    reg_wr(2'd0, 16'h0001);
    @(negedge clk_i);
    idle_cycles(10, h); check("R2 period1 high cycles", h, 3);
    idle_cycles(10, h); check("R2 zero duty period", h, 0);
    idle_cycles(10, h); check("R8 period3 high cycles", h, 5);
    idle_cycles(10, h); check("R8 empty repeats last", h, 5);
    reg_rd(2'd1, d); check("R8 active duty", d, 5);
    reg_rd(2'd3, d); check("R8 queue drained", d[4:0], 5'h10);
    reg_wr(2'd0, 16'h0000);
  endtask

  task automatic t_idle_and_overflow;
    logic [15:0] d;
    int h;
    reg_wr(2'd0, 16'h0004);
    reg_rd(2'd2, d); check("R7 period kept", d, 9);
    reg_wr(2'd1, 16'd1);
    reg_wr(2'd1, 16'd2);
    idle_cycles(30, h); check("R6 no output when disabled", h, 0);
    reg_rd(2'd3, d); check("R6 no consumption when disabled", d, 16'h0002);
    reg_wr(2'd1, 16'd3);
    reg_wr(2'd1, 16'd4);
    reg_rd(2'd3, d); check("R1 full no error", d, 16'h0004);
    reg_wr(2'd1, 16'd8);
    reg_rd(2'd3, d); check("R3 error set sample dropped", d, 16'h0024);
    reg_wr(2'd0, 16'h0001);
    idle_cycles(25, h); check("R4 no output with error", h, 0);
    reg_rd(2'd3, d); check("R4 no consumption with error", d, 16'h0024);
    reg_wr(2'd3, 16'h0000);
    reg_rd(2'd3, d); check("R9 write zero keeps error", d[5], 1);
    reg_wr(2'd3, 16'h0020);
    idle_cycles(50, h); check("R4 starts after clear", h > 0, 1);
    reg_rd(2'd3, d); check("R9 error cleared and drained", d[5:0], 6'h10);
    reg_rd(2'd1, d); check("R3 overflow sample discarded", d, 4);
    reg_wr(2'd0, 16'h0000);
  endtask

  task automatic t_soft_reset;
    logic [15:0] d;
    for (int i = 0; i < 5; i++) reg_wr(2'd1, 16'd2);
    reg_rd(2'd3, d); check("R3 error before soft reset", d, 16'h0064);
    reg_wr(2'd0, 16'h0007);
    reg_rd(2'd3, d); check("R7 status after soft reset", d, 16'h0010);
    reg_rd(2'd0, d); check("R7 ctrl cleared", d, 0);
    reg_rd(2'd1, d); check("R7 duty cleared", d, 0);
    reg_rd(2'd2, d); check("R7 period unchanged", d, 9);
  endtask

  task automatic t_rollover;
    logic [15:0] d;
    int h;
    reg_wr(2'd1, 16'd0);
    reg_wr(2'd0, 16'h0001);
    idle_cycles(35, h); check("R2 zero duty stays low", h, 0);
    reg_rd(2'd3, d); check("R5 no rollover on zero duty", d[6], 0);
    reg_wr(2'd1, 16'd2);
    idle_cycles(25, h);
    reg_rd(2'd3, d); check("R5 rollover after nonzero period", d[6], 1);
    check("R10 irq gated off", irq_o, 0);
    reg_wr(2'd0, 16'h0003);
    check("R10 irq with enable", irq_o, 1);
    reg_wr(2'd0, 16'h0002);
    reg_wr(2'd3, 16'h0040);
    reg_rd(2'd3, d); check("R9 rollover cleared", d[6], 0);
    check("R10 irq drops", irq_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_sequence();
    t_idle_and_overflow();
    t_soft_reset();
    t_rollover();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule